// File: doc/BRIEF.md
# Load Result Use Vitality Classifier

This block sits beside the physical register file of an out-of-order core and decides, for every executed load, whether its result was needed at once. Each physical register carries a 2-bit tag and a copy of the instruction pointer of the load that last wrote it. When a load writes back, the tag of its destination register goes pending. On the next clock the block looks at the issue stage's read mask. If that register is read in that cycle, the load is judged vital; otherwise it is judged non-vital.

A register whose tag has reached a final state owes one classification event. The block sends these events out one per cycle, each as a single-cycle pulse carrying the load's instruction pointer and a vital bit. A per-static-load vitality table downstream consumes them.

Several writeback ports may retire loads in the same cycle, so several registers can finish at once. The owed tags themselves act as the queue, and the lowest register index is served first. A pipeline flush, or reset, returns every tag to idle and drops all owed events. The reset input is expected to be asserted asynchronously and already released in step with the clock.

Top module: `load_vitality_classifier`

## Requirements
- R1: While reset is asserted, and after it is released, no event is produced until a new load writes back; a load whose classification was still open when reset arrived never produces an event.
- R2: A writeback with its load flag set moves the destination register's tag from idle (00) to pending (01) and records that writeback's instruction pointer; the event for that load carries this pointer.
- R3: If a pending register's bit in the read mask (bit r stands for physical register r) is 0 in the cycle after the load's write, the tag becomes non-vital (10) and the event has its vital bit at 0.
- R4: If that read-mask bit is 1 in the cycle after the load's write, the tag becomes vital (11) and the event has its vital bit at 1.
- R5: A read of the register in the same cycle as the load's write, or two or more cycles after it, does not affect the classification.
- R6: Every dynamic load is classified afresh. A new load write to a register replaces any classification of that register that is still pending or owed, so only the newest load's event is produced, and it can differ from the earlier one.
- R7: A writeback with its load flag clear returns the destination register's tag to idle (00). It cancels any pending or owed classification for that register and produces no event.
- R8: When several registers hold final tags at once, one event is produced per cycle, in ascending order of register index. Each register waiting its turn keeps its tag and pointer unchanged.
- R9: Asserting the flush input for one cycle returns all tags to idle. The event output is low in the following cycle, and no classification owed or pending at the flush is ever produced.
- R10: The pass through the block has a fixed length. For a load written at clock edge k, with the read mask checked at edge k+1 and no other register waiting, the event is valid for exactly one cycle right after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| flush_i | input | 1 | Pipeline flush; clears all tags and owed events |
| wb_vld_i | input | NUM_WB | Writeback valid, one bit per writeback port |
| wb_is_load_i | input | NUM_WB | The writeback on this port comes from a load |
| wb_preg_i | input | NUM_WB*PREG_W | Destination physical register per port, port 0 in the low bits |
| wb_ip_i | input | NUM_WB*IP_W | Instruction pointer of the writing instruction per port, port 0 in the low bits |
| rd_mask_i | input | NUM_PREG | Physical registers read by the issue stage this cycle, bit r for register r |
| evt_vld_o | output | 1 | Classification event valid, one-cycle pulse per event |
| evt_ip_o | output | IP_W | Instruction pointer of the classified load |
| evt_vital_o | output | 1 | 1 = vital (result read at once), 0 = non-vital |

## Verification
Two things can collide in one cycle. The first is two loads writing back together on different ports, so that both registers reach a final state at the same edge and compete for the single event output. The bench provokes this with one load that is read on the next cycle and one that is not. It then expects the lower-numbered register's event first and the other on the following cycle, each with its own vital bit. The second collision is a new write to a register in the same cycle that its pending load is being judged. The bench expects the newer load to win: the older load's event never appears, and the newer one is classified on its own next-cycle read.

// File: rtl/lvc_pkg.sv
package lvc_pkg;

  // Vitality tag encoding; the high bit marks a finished classification,
  // the low bit of a finished tag is the vital flag sent with the event.
  typedef enum logic [1:0] {
    TAG_IDLE = 2'b00,
    TAG_PEND = 2'b01,
    TAG_NONV = 2'b10,
    TAG_VITL = 2'b11
  } vtag_e;

endpackage

// File: rtl/lvc_wb_decode.sv
module lvc_wb_decode #(
  parameter int NUM_PREG = 16,
  parameter int NUM_WB   = 2,
  parameter int IP_W     = 16,
  localparam int PREG_W  = $clog2(NUM_PREG)
) (
  input  logic [NUM_WB-1:0]            wb_vld_i,
  input  logic [NUM_WB-1:0]            wb_is_load_i,
  input  logic [NUM_WB*PREG_W-1:0]     wb_preg_i,
  input  logic [NUM_WB*IP_W-1:0]       wb_ip_i,
  output logic [NUM_PREG-1:0]          hit_o,
  output logic [NUM_PREG-1:0]          is_load_o,
  output logic [NUM_PREG-1:0][IP_W-1:0] ip_o
);

  logic [PREG_W-1:0] sel;

  // Fan each writeback port out to its destination register.
  // A higher-numbered port overrides a lower one on the same register.
  always_comb begin
    hit_o     = '0;
    is_load_o = '0;
    ip_o      = '0;
    sel       = '0;
    for (int p = 0; p < NUM_WB; p++) begin
      sel = wb_preg_i[p*PREG_W +: PREG_W];
      if (wb_vld_i[p] && (int'(sel) < NUM_PREG)) begin
        hit_o[sel]     = 1'b1;
        is_load_o[sel] = wb_is_load_i[p];
        ip_o[sel]      = wb_ip_i[p*IP_W +: IP_W];
      end
    end
  end

endmodule

// File: rtl/lvc_tag_slot.sv
module lvc_tag_slot
  import lvc_pkg::*;
#(
  parameter int IP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            wr_i,
  input  logic            wr_load_i,
  input  logic [IP_W-1:0] wr_ip_i,
  input  logic            rd_i,
  input  logic            grant_i,
  output logic [1:0]      tag_o,
  output logic [IP_W-1:0] ip_o
);

  vtag_e           tag_q, tag_d;
  logic [IP_W-1:0] ip_q;
  logic            ip_en;

  assign ip_en = wr_i & wr_load_i & ~flush_i;

  // Next-state: flush beats write, write beats the read check and the grant.
  always_comb begin
    tag_d = tag_q;
    if (flush_i) begin
      tag_d = TAG_IDLE;
    end else if (wr_i) begin
      tag_d = wr_load_i ? TAG_PEND : TAG_IDLE;
    end else begin
      unique case (tag_q)
        TAG_PEND: tag_d = rd_i ? TAG_VITL : TAG_NONV;
        TAG_NONV,
        TAG_VITL: tag_d = grant_i ? TAG_IDLE : tag_q;
        default:  tag_d = tag_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= TAG_IDLE;
      ip_q  <= '0;
    end else begin
      tag_q <= tag_d;
      if (ip_en) ip_q <= wr_ip_i;
    end
  end

  assign tag_o = tag_q;
  assign ip_o  = ip_q;

  // R2
  load_write_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_load_i && !flush_i) |=> (tag_q == TAG_PEND && ip_q == $past(wr_ip_i)));

  // R3
  pend_noread_nonv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_PEND && !wr_i && !rd_i && !flush_i) |=> (tag_q == TAG_NONV));

  // R4
  pend_read_vital_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_PEND && !wr_i && rd_i && !flush_i) |=> (tag_q == TAG_VITL));

  // R7
  nonload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wr_load_i && !flush_i) |=> (tag_q == TAG_IDLE));

  // R8
  waiting_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q[1] && !grant_i && !wr_i && !flush_i) |=> ($stable(tag_q) && $stable(ip_q)));

  // R9
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (tag_q == TAG_IDLE));

endmodule

// File: rtl/lvc_pick.sv
module lvc_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  // Fixed priority: the lowest requesting index wins.
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/load_vitality_classifier.sv
module load_vitality_classifier #(
  parameter int NUM_PREG = 16,
  parameter int NUM_WB   = 2,
  parameter int IP_W     = 16,
  localparam int PREG_W  = $clog2(NUM_PREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush_i,
  input  logic [NUM_WB-1:0]         wb_vld_i,
  input  logic [NUM_WB-1:0]         wb_is_load_i,
  input  logic [NUM_WB*PREG_W-1:0]  wb_preg_i,
  input  logic [NUM_WB*IP_W-1:0]    wb_ip_i,
  input  logic [NUM_PREG-1:0]       rd_mask_i,
  output logic                      evt_vld_o,
  output logic [IP_W-1:0]           evt_ip_o,
  output logic                      evt_vital_o
);

  logic [NUM_PREG-1:0]            wr_hit;
  logic [NUM_PREG-1:0]            wr_load;
  logic [NUM_PREG-1:0][IP_W-1:0]  wr_ip;
  logic [NUM_PREG-1:0][1:0]       slot_tag;
  logic [NUM_PREG-1:0][IP_W-1:0]  slot_ip;
  logic [NUM_PREG-1:0]            slot_req;
  logic [NUM_PREG-1:0]            pick_grant;
  logic [NUM_PREG-1:0]            slot_grant;
  logic [PREG_W-1:0]              pick_idx;
  logic                           pick_any;

  logic                           evt_vld_q, evt_vld_d;
  logic [IP_W-1:0]                evt_ip_q, evt_ip_d;
  logic                           evt_vital_q, evt_vital_d;
  logic                           evt_en;

  lvc_wb_decode #(
    .NUM_PREG (NUM_PREG),
    .NUM_WB   (NUM_WB),
    .IP_W     (IP_W)
  ) u_decode (
    .wb_vld_i     (wb_vld_i),
    .wb_is_load_i (wb_is_load_i),
    .wb_preg_i    (wb_preg_i),
    .wb_ip_i      (wb_ip_i),
    .hit_o        (wr_hit),
    .is_load_o    (wr_load),
    .ip_o         (wr_ip)
  );

  for (genvar r = 0; r < NUM_PREG; r++) begin : g_slot
    lvc_tag_slot #(
      .IP_W (IP_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_i),
      .wr_i      (wr_hit[r]),
      .wr_load_i (wr_load[r]),
      .wr_ip_i   (wr_ip[r]),
      .rd_i      (rd_mask_i[r]),
      .grant_i   (slot_grant[r]),
      .tag_o     (slot_tag[r]),
      .ip_o      (slot_ip[r])
    );
    assign slot_req[r] = slot_tag[r][1];
  end

  lvc_pick #(
    .N (NUM_PREG)
  ) u_pick (
    .req_i   (slot_req),
    .grant_o (pick_grant),
    .idx_o   (pick_idx),
    .any_o   (pick_any)
  );

  assign slot_grant = pick_grant & {NUM_PREG{~flush_i}};

  // Event register: next-state, then storage with an explicit enable.
  always_comb begin
    evt_vld_d   = pick_any & ~flush_i;
    evt_en      = pick_any & ~flush_i;
    evt_ip_d    = slot_ip[pick_idx];
    evt_vital_d = slot_tag[pick_idx][0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_vld_q   <= 1'b0;
      evt_ip_q    <= '0;
      evt_vital_q <= 1'b0;
    end else begin
      evt_vld_q <= evt_vld_d;
      if (evt_en) begin
        evt_ip_q    <= evt_ip_d;
        evt_vital_q <= evt_vital_d;
      end
    end
  end

  assign evt_vld_o   = evt_vld_q;
  assign evt_ip_o    = evt_ip_q;
  assign evt_vital_o = evt_vital_q;

  // R8
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_grant != '0) |-> ((slot_req & (pick_grant - 1'b1)) == '0));

  // R9
  flush_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !evt_vld_o);

  // R1
  idle_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req == '0) |=> !evt_vld_o);

endmodule

// File: tb/load_vitality_classifier_bench.sv
module load_vitality_classifier_bench;

  localparam int NUM_PREG = 16;
  localparam int NUM_WB   = 2;
  localparam int IP_W     = 16;
  localparam int PREG_W   = 4;

  logic                     clk;
  logic                     rst_n;
  logic                     flush_i;
  logic [NUM_WB-1:0]        wb_vld_i;
  logic [NUM_WB-1:0]        wb_is_load_i;
  logic [NUM_WB*PREG_W-1:0] wb_preg_i;
  logic [NUM_WB*IP_W-1:0]   wb_ip_i;
  logic [NUM_PREG-1:0]      rd_mask_i;
  logic                     evt_vld_o;
  logic [IP_W-1:0]          evt_ip_o;
  logic                     evt_vital_o;

  int n_run  = 0;
  int n_fail = 0;

  load_vitality_classifier #(
    .NUM_PREG (NUM_PREG),
    .NUM_WB   (NUM_WB),
    .IP_W     (IP_W)
  ) u_load_vitality_classifier (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .wb_vld_i     (wb_vld_i),
    .wb_is_load_i (wb_is_load_i),
    .wb_preg_i    (wb_preg_i),
    .wb_ip_i      (wb_ip_i),
    .rd_mask_i    (rd_mask_i),
    .evt_vld_o    (evt_vld_o),
    .evt_ip_o     (evt_ip_o),
    .evt_vital_o  (evt_vital_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // One row per cycle: inputs applied, and the event expected on the
  // outputs at that moment (result of the previous clock edge).
  typedef struct packed {
    logic [1:0]  wv;
    logic [1:0]  wl;
    logic [3:0]  p1;
    logic [15:0] ip1;
    logic [3:0]  p0;
    logic [15:0] ip0;
    logic [15:0] rd;
    logic        ev;
    logic        evit;
    logic [15:0] eip;
    logic [7:0]  rq;
  } row_t;

  localparam int NV = 32;
  localparam row_t VEC [NV] = '{
    // R4: p3 written, read next cycle -> vital
    '{2'b01, 2'b01, 4'd0, 16'h0000, 4'd3, 16'h0100, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd4},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0008, 1'b0, 1'b0, 16'h0000, 8'd4},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd10},
    // R3: p5 written, not read -> non-vital; R10: p3 event appears here
    '{2'b01, 2'b01, 4'd0, 16'h0000, 4'd5, 16'h0200, 16'h0000, 1'b1, 1'b1, 16'h0100, 8'd4},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd10},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd3},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0200, 8'd3},
    // R5: reads in the write cycle and two cycles later do not count
    '{2'b01, 2'b01, 4'd0, 16'h0000, 4'd2, 16'h0300, 16'h0004, 1'b0, 1'b0, 16'h0000, 8'd5},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd5},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0004, 1'b0, 1'b0, 16'h0000, 8'd5},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0300, 8'd5},
    // R7: non-load write to p4 while pending cancels it
    '{2'b01, 2'b01, 4'd0, 16'h0000, 4'd4, 16'h0400, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd7},
    '{2'b01, 2'b00, 4'd0, 16'h0000, 4'd4, 16'h0000, 16'h0010, 1'b0, 1'b0, 16'h0000, 8'd7},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd7},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd7},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd7},
    // R8: p9 (port 0) and p6 (port 1) together; only p9 read
    '{2'b11, 2'b11, 4'd6, 16'h0600, 4'd9, 16'h0900, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd8},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0200, 1'b0, 1'b0, 16'h0000, 8'd8},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd8},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0600, 8'd8},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'h0900, 8'd8},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd8},
    // R6: second load to p7 while the first is pending replaces it
    '{2'b01, 2'b01, 4'd0, 16'h0000, 4'd7, 16'h0700, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd6},
    '{2'b01, 2'b01, 4'd0, 16'h0000, 4'd7, 16'h0710, 16'h0080, 1'b0, 1'b0, 16'h0000, 8'd6},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd6},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd6},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0710, 8'd6},
    // R6: same register, next dynamic load read at once -> vital now
    '{2'b01, 2'b01, 4'd0, 16'h0000, 4'd7, 16'h0720, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd6},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0080, 1'b0, 1'b0, 16'h0000, 8'd6},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd6},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'h0720, 8'd6},
    '{2'b00, 2'b00, 4'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd10}
  };

  task automatic check_evt(input string tag, input logic ev, input logic evit,
                           input logic [15:0] eip);
    logic ok;
    n_run++;
    ok = (evt_vld_o === ev);
    if (ev) ok = ok && (evt_vital_o === evit) && (evt_ip_o === eip);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual vld=%b vital=%b ip=%h, expected vld=%b vital=%b ip=%h",
               tag, evt_vld_o, evt_vital_o, evt_ip_o, ev, evit, eip);
    end
  endtask

  task automatic drive_idle();
    wb_vld_i     = '0;
    wb_is_load_i = '0;
    wb_preg_i    = '0;
    wb_ip_i      = '0;
    rd_mask_i    = '0;
    flush_i      = 1'b0;
  endtask

  task automatic drive_load(input logic [3:0] p0, input logic [15:0] ip0,
                            input logic use1, input logic [3:0] p1,
                            input logic [15:0] ip1);
    wb_vld_i     = {use1, 1'b1};
    wb_is_load_i = {use1, 1'b1};
    wb_preg_i    = {p1, p0};
    wb_ip_i      = {ip1, ip0};
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual run still going, expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_evt("R1 during reset", 1'b0, 1'b0, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs clear after reset
    n_run++;
    if (evt_vld_o !== 1'b0 || evt_ip_o !== 16'h0 || evt_vital_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state: actual %b/%h/%b, expected 0/0000/0",
               evt_vld_o, evt_ip_o, evt_vital_o);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_evt($sformatf("R%0d row %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].evit, VEC[i].eip);
      wb_vld_i     = VEC[i].wv;
      wb_is_load_i = VEC[i].wl;
      wb_preg_i    = {VEC[i].p1, VEC[i].p0};
      wb_ip_i      = {VEC[i].ip1, VEC[i].ip0};
      rd_mask_i    = VEC[i].rd;
    end
    @(negedge clk);
    drive_idle();
    repeat (3) @(negedge clk);

    // R9: two owed events, flush after the first is sent
    drive_load(4'd1, 16'h0A00, 1'b1, 4'd8, 16'h0B00);
    @(negedge clk); drive_idle();
    @(negedge clk);
    @(negedge clk);
    check_evt("R9 first event before flush", 1'b1, 1'b0, 16'h0A00);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    check_evt("R9 after flush", 1'b0, 1'b0, 16'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_evt("R9 owed event dropped", 1'b0, 1'b0, 16'h0);
    end

    // R9: flush while pending, read in the check cycle
    drive_load(4'd3, 16'h0C00, 1'b0, 4'd0, 16'h0);
    @(negedge clk);
    drive_idle();
    flush_i   = 1'b1;
    rd_mask_i = 16'h0008;
    @(negedge clk);
    drive_idle();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_evt("R9 pending dropped", 1'b0, 1'b0, 16'h0);
    end

    // R1: reset while a load is pending
    drive_load(4'd3, 16'h0D00, 1'b0, 4'd0, 16'h0);
    @(negedge clk);
    drive_idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_evt("R1 pending dropped by reset", 1'b0, 1'b0, 16'h0);
    end

    // R2/R10: single load on port 1, pointer carried through
    wb_vld_i = 2'b10; wb_is_load_i = 2'b10;
    wb_preg_i = {4'd15, 4'd0}; wb_ip_i = {16'hBEEF, 16'h0};
    @(negedge clk); drive_idle();
    @(negedge clk);
    check_evt("R10 not yet", 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    check_evt("R2 pointer on event", 1'b1, 1'b0, 16'hBEEF);
    @(negedge clk);
    check_evt("R10 single cycle", 1'b0, 1'b0, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule